// File: doc/BRIEF.md
# DMA Controller CPU Register Window

This block is the processor-side register window of a floppy and hard-disk DMA controller. It sits on a 16-bit CPU bus that is shared in four time slots. A free-running 2-bit phase count, supplied from outside, marks the slots, and the processor owns slot 0. The block decodes a 16-byte I/O region, holds the 24-bit transfer address as three byte registers, and holds a 9-bit mode register. It also provides one data port. A mode bit steers that port either to the sector counter or to the registers of the external disk controller.

The block presents the current address, the sector count, the direction and the other mode outputs to the DMA engine. Storing a nonzero sector count sends a one-cycle start pulse to the engine. Read data is combinational during the accepted slot, so it is stable well before the falling clock edge inside slot 0.

Top module: `dma_cpu_window`

## Requirements
- R1: While `rst_n` is low at a rising edge, the registers clear and CPU writes have no effect. After that edge, `dma_addr` and `dma_count` read 0. The mode register holds 0x040: DMA off, direction 0, floppy 0. `dma_start` and `dsk_wr` stay 0.
- R2: An access is taken only when three conditions hold at once. `cpu_sel` is 1, `bus_phase` is 0, and `cpu_addr[23:4]` equals the base 0xFF860. Otherwise a write changes nothing and `cpu_dout` is 0.
- R3: A write to word index `cpu_addr[3:1]` = 4, 5 or 6 (byte offsets 9, B and D) loads `cpu_din[7:0]` into address bits 23:16, 15:8 or 7:0. The write needs the low lane (`cpu_lds_n` = 0). A write that uses only the upper lane leaves the byte unchanged.
- R4: Mode register, word index 3, field layout:
  - bit 8 is the direction (1 = write to disk), driven on `dma_dir_out`;
  - bit 7 is the floppy select, on `dma_floppy`;
  - bit 6 is DMA off, on `dma_off`;
  - bit 4 is the count select;
  - bit 3 is the hard-disk register select, on `dsk_hd_regs`;
  - bits 2:1 are the controller register select, on `dsk_reg`.

  The upper lane writes bit 8 and the low lane writes bits 7:0. Bits 5 and 0 always read 0. A read returns the register in `cpu_dout[8:0]`.
- R5: With mode bit 4 set, a low-lane write to word index 2 loads `dma_count` from `cpu_din[7:0]`. A read of index 2 returns the count in the low byte.
- R6: A sector count write of a nonzero value raises `dma_start` for exactly the one cycle after the accepting edge. A write of zero raises nothing.
- R7: With mode bit 4 clear, a low-lane write to index 2 raises `dsk_wr` combinationally during the slot, with `dsk_wdata` = `cpu_din[7:0]`, and leaves the count unchanged. A read raises `dsk_rd` and returns `dsk_rdata` in the low byte.
- R8: A read is driven combinationally while the access is held. Word indices 0, 1 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_phase | input | 2 | Free-running bus slot number; 0 is the CPU slot |
| cpu_sel | input | 1 | CPU peripheral select |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_addr | input | 23 | CPU word address, bits 23:1 |
| cpu_uds_n | input | 1 | Upper byte lane strobe, active low |
| cpu_lds_n | input | 1 | Lower byte lane strobe, active low |
| cpu_din | input | 16 | CPU write data |
| cpu_dout | output | 16 | CPU read data |
| dma_addr | output | 24 | Current DMA byte address |
| dma_count | output | 8 | Sector count |
| dma_dir_out | output | 1 | Direction, 1 = toward disk |
| dma_floppy | output | 1 | Floppy (1) or hard disk (0) transfer |
| dma_off | output | 1 | DMA disabled |
| dma_start | output | 1 | One-cycle start request |
| dsk_wr | output | 1 | Controller register write strobe |
| dsk_rd | output | 1 | Controller register read strobe |
| dsk_hd_regs | output | 1 | Selects hard-disk instead of floppy registers |
| dsk_reg | output | 2 | Controller register select |
| dsk_wdata | output | 8 | Controller write data |
| dsk_rdata | input | 8 | Controller read data |

## Verification
The hardest state to reach from the ports depends on earlier mode writes. The same write to the data port must go to the counter and possibly start a transfer in one case, and go to the disk controller without touching the count in the other. The bench reaches both by interleaving random mode-register writes, with random lane strobes, with random data-port writes. Every expectation is computed against the mode value the bench model holds at that moment.

The bench also drives directed cases for:
- writes during reset;
- writes in a non-zero slot;
- writes outside the base region;
- upper-lane-only writes;
- a zero count.

// File: rtl/dma_win_pkg.sv
// Shared constants and the mode register layout of the DMA CPU window.
package dma_win_pkg;
    // Word indices (CPU address bits 3:1) decoded inside the region
    localparam int IDX_DATA    = 2;
    localparam int IDX_MODE    = 3;
    localparam int IDX_ADDR_LO = 6;   // lower indices hold more significant bytes

    // Mode register layout; bit positions are decoded by the DMA engine
    typedef struct packed {
        logic       dir_out;    // 8
        logic       floppy_dma; // 7
        logic       dma_off;    // 6
        logic       rsvd5;      // 5
        logic       count_sel;  // 4
        logic       hd_regs;    // 3
        logic [1:0] ctl_reg;    // 2:1
        logic       rsvd0;      // 0
    } mode_t;

    localparam logic [8:0] MODE_RESET   = 9'h040;
    localparam logic [7:0] MODE_LO_MASK = 8'hDE;
endpackage

// File: rtl/dma_win_decode.sv
// Bus decoder: qualifies a CPU access by select, slot 0 and region base,
// and splits it into lane-qualified write enables and a read enable.
// Assumes the CPU holds its signals for the whole slot-0 clock.
module dma_win_decode #(
    parameter int              ADDR_W  = 24,
    parameter logic [ADDR_W-1:0] IO_BASE = 24'hFF8600
) (
    input  logic [1:0]        bus_phase,
    input  logic              cpu_sel,
    input  logic              cpu_rw,
    input  logic [ADDR_W-1:1] cpu_addr,
    input  logic              cpu_uds_n,
    input  logic              cpu_lds_n,
    output logic              acc_wr_lo,
    output logic              acc_wr_hi,
    output logic              acc_rd,
    output logic [2:0]        acc_idx
);
    logic hit;

    // Region hit: CPU slot, select and base match on bits above 3
    always_comb begin
        hit       = cpu_sel && (bus_phase == 2'd0) &&
                    (cpu_addr[ADDR_W-1:4] == IO_BASE[ADDR_W-1:4]);
        acc_wr_lo = hit && !cpu_rw && !cpu_lds_n;
        acc_wr_hi = hit && !cpu_rw && !cpu_uds_n;
        acc_rd    = hit && cpu_rw;
        acc_idx   = cpu_addr[3:1];
    end
endmodule

// File: rtl/dma_win_addr_regs.sv
// DMA address storage: one byte register per address byte, each written
// from the low data lane at its own word index. Assumes ADDR_W is a
// multiple of 8 and the byte count fits below IDX_ADDR_LO.
module dma_win_addr_regs
    import dma_win_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_wr_lo,
    input  logic [2:0]        acc_idx,
    input  logic [7:0]        wdata,
    output logic [ADDR_W-1:0] dma_addr
);
    localparam int NBYTES = ADDR_W / 8;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        localparam logic [2:0] MY_IDX = 3'(IDX_ADDR_LO - b);
        logic [7:0] byte_q;

        // Byte register: clear on reset, load on a low-lane write to its index
        always_ff @(posedge clk) begin
            if (!rst_n)
                byte_q <= '0;
            else if (acc_wr_lo && (acc_idx == MY_IDX))
                byte_q <= wdata;
        end

        assign dma_addr[8*b +: 8] = byte_q;
    end
endmodule

// File: rtl/dma_win_ctrl.sv
// Mode register, sector counter and start pulse generator. The count is
// written only when the mode selects it; a nonzero count arms the engine.
module dma_win_ctrl
    import dma_win_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_wr_lo,
    input  logic             acc_wr_hi,
    input  logic [2:0]       acc_idx,
    input  logic [8:0]       wdata,
    output mode_t            mode,
    output logic [CNT_W-1:0] count,
    output logic             start
);
    logic mode_hit, cnt_wr;
    mode_t mode_nxt;

    // Next mode value from the lanes that are enabled
    always_comb begin
        mode_hit = (acc_idx == 3'(IDX_MODE));
        mode_nxt = mode;
        if (mode_hit && acc_wr_hi)
            mode_nxt.dir_out = wdata[8];
        if (mode_hit && acc_wr_lo)
            mode_nxt[7:0] = wdata[7:0] & MODE_LO_MASK;
        cnt_wr = acc_wr_lo && (acc_idx == 3'(IDX_DATA)) && mode.count_sel;
    end

    // Mode storage, reset to DMA off
    always_ff @(posedge clk) begin
        if (!rst_n) mode <= mode_t'(MODE_RESET);
        else        mode <= mode_nxt;
    end

    // Sector count and one-cycle start on a nonzero count write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            start <= 1'b0;
        end else begin
            start <= cnt_wr && (wdata[CNT_W-1:0] != '0);
            if (cnt_wr) count <= wdata[CNT_W-1:0];
        end
    end
endmodule

// File: rtl/dma_cpu_window.sv
// Top of the DMA CPU register window: decode, address bytes, mode/count,
// read-back multiplexer and the pass-through to the disk controller.
// Read data is combinational during the accepted slot.
module dma_cpu_window
    import dma_win_pkg::*;
#(
    parameter int                ADDR_W  = 24,
    parameter logic [ADDR_W-1:0] IO_BASE = 24'hFF8600,
    parameter int                CNT_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_phase,
    input  logic              cpu_sel,
    input  logic              cpu_rw,
    input  logic [ADDR_W-1:1] cpu_addr,
    input  logic              cpu_uds_n,
    input  logic              cpu_lds_n,
    input  logic [15:0]       cpu_din,
    output logic [15:0]       cpu_dout,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [CNT_W-1:0]  dma_count,
    output logic              dma_dir_out,
    output logic              dma_floppy,
    output logic              dma_off,
    output logic              dma_start,
    output logic              dsk_wr,
    output logic              dsk_rd,
    output logic              dsk_hd_regs,
    output logic [1:0]        dsk_reg,
    output logic [7:0]        dsk_wdata,
    input  logic [7:0]        dsk_rdata
);
    localparam int NBYTES = ADDR_W / 8;

    logic       acc_wr_lo, acc_wr_hi, acc_rd;
    logic [2:0] acc_idx;
    mode_t      mode;
    logic       data_idx;
    logic       unused_din_hi;

    dma_win_decode #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) u_decode (
        .bus_phase (bus_phase),
        .cpu_sel   (cpu_sel),
        .cpu_rw    (cpu_rw),
        .cpu_addr  (cpu_addr),
        .cpu_uds_n (cpu_uds_n),
        .cpu_lds_n (cpu_lds_n),
        .acc_wr_lo (acc_wr_lo),
        .acc_wr_hi (acc_wr_hi),
        .acc_rd    (acc_rd),
        .acc_idx   (acc_idx)
    );

    dma_win_addr_regs #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_wr_lo (acc_wr_lo),
        .acc_idx   (acc_idx),
        .wdata     (cpu_din[7:0]),
        .dma_addr  (dma_addr)
    );

    dma_win_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_wr_lo (acc_wr_lo),
        .acc_wr_hi (acc_wr_hi),
        .acc_idx   (acc_idx),
        .wdata     (cpu_din[8:0]),
        .mode      (mode),
        .count     (dma_count),
        .start     (dma_start)
    );

    assign unused_din_hi = ^cpu_din[15:9];

    // Mode fields toward the engine and the disk controller
    always_comb begin
        dma_dir_out = mode.dir_out;
        dma_floppy  = mode.floppy_dma;
        dma_off     = mode.dma_off;
        dsk_hd_regs = mode.hd_regs;
        dsk_reg     = mode.ctl_reg;
        dsk_wdata   = cpu_din[7:0];
    end

    // Controller strobes when the data port is not steered to the count
    always_comb begin
        data_idx = (acc_idx == 3'(IDX_DATA)) && !mode.count_sel;
        dsk_wr   = rst_n && acc_wr_lo && data_idx;
        dsk_rd   = acc_rd && data_idx;
    end

    // Read-back multiplexer, zero outside an accepted read
    always_comb begin
        cpu_dout = '0;
        if (acc_rd) begin
            if (acc_idx == 3'(IDX_DATA))
                cpu_dout = mode.count_sel ? 16'(dma_count) : {8'h00, dsk_rdata};
            else if (acc_idx == 3'(IDX_MODE))
                cpu_dout = {7'h00, mode};
            for (int b = 0; b < NBYTES; b++)
                if (acc_idx == 3'(IDX_ADDR_LO - b))
                    cpu_dout = {8'h00, dma_addr[8*b +: 8]};
        end
    end
endmodule

// File: rtl/dma_cpu_window_chk.sv
// Checker for the DMA CPU window, attached to every instance by bind.
module dma_cpu_window_chk #(
    parameter int                ADDR_W  = 24,
    parameter logic [ADDR_W-1:0] IO_BASE = 24'hFF8600,
    parameter int                CNT_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        bus_phase,
    input logic              cpu_sel,
    input logic              cpu_rw,
    input logic [ADDR_W-1:1] cpu_addr,
    input logic              cpu_lds_n,
    input logic [7:0]        cpu_din_lo,
    input logic [15:0]       cpu_dout,
    input logic [ADDR_W-1:0] dma_addr,
    input logic [CNT_W-1:0]  dma_count,
    input logic              dma_start,
    input logic              dsk_wr,
    input logic              dsk_rd
);
    // R6
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> $past(cpu_sel && bus_phase == 2'd0 && !cpu_rw && !cpu_lds_n &&
                            cpu_addr[ADDR_W-1:4] == IO_BASE[ADDR_W-1:4] &&
                            cpu_addr[3:1] == 3'd2 && cpu_din_lo != 8'h00));

    // R6
    start_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> dma_count != '0);

    // R2
    slot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_phase != 2'd0 |=> $stable(dma_addr) && $stable(dma_count));

    // R2
    idle_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_sel && bus_phase == 2'd0) |-> cpu_dout == 16'h0000);

    // R7
    dsk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dsk_wr, dsk_rd}));

    // R7
    dsk_wr_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsk_wr |-> !cpu_rw && !cpu_lds_n && bus_phase == 2'd0);
endmodule

bind dma_cpu_window dma_cpu_window_chk #(
    .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .CNT_W(CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_phase  (bus_phase),
    .cpu_sel    (cpu_sel),
    .cpu_rw     (cpu_rw),
    .cpu_addr   (cpu_addr),
    .cpu_lds_n  (cpu_lds_n),
    .cpu_din_lo (cpu_din[7:0]),
    .cpu_dout   (cpu_dout),
    .dma_addr   (dma_addr),
    .dma_count  (dma_count),
    .dma_start  (dma_start),
    .dsk_wr     (dsk_wr),
    .dsk_rd     (dsk_rd)
);

// File: tb/dma_cpu_window_test.sv
// Bench for the DMA CPU window: directed corners plus seeded random traffic.
module dma_cpu_window_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_phase = 2'd1;
    logic        cpu_sel = 1'b0, cpu_rw = 1'b1;
    logic [23:1] cpu_addr = '0;
    logic        cpu_uds_n = 1'b1, cpu_lds_n = 1'b1;
    logic [15:0] cpu_din = '0;
    logic [15:0] cpu_dout;
    logic [23:0] dma_addr;
    logic [7:0]  dma_count;
    logic        dma_dir_out, dma_floppy, dma_off, dma_start;
    logic        dsk_wr, dsk_rd, dsk_hd_regs;
    logic [1:0]  dsk_reg;
    logic [7:0]  dsk_wdata;
    logic [7:0]  dsk_rdata = 8'h00;

    dma_cpu_window uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, fails = 0;
    bit done = 0;

    // Bench model of the registers
    logic [23:0] m_addr = '0;
    logic [8:0]  m_mode = 9'h040;
    logic [7:0]  m_cnt  = '0;

    // Captures from the last bus operation
    logic [15:0] c_dout;
    logic        c_wr, c_rd, c_hd, c_st1, c_st2;
    logic [1:0]  c_reg;
    logic [7:0]  c_wd;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] f_mode(input logic [8:0] old, input logic [15:0] d,
                                          input logic hi, input logic lo);
        logic [8:0] r = old;
        if (hi) r[8] = d[8];
        if (lo) r[7:0] = d[7:0] & 8'hDE;
        return r;
    endfunction

    function automatic logic [15:0] f_read(input logic [2:0] idx, input logic [7:0] rd);
        case (idx)
            3'd2:    return m_mode[4] ? {8'h00, m_cnt} : {8'h00, rd};
            3'd3:    return {7'h00, m_mode};
            3'd4:    return {8'h00, m_addr[23:16]};
            3'd5:    return {8'h00, m_addr[15:8]};
            3'd6:    return {8'h00, m_addr[7:0]};
            default: return 16'h0000;
        endcase
    endfunction

    // One bus slot: drive at a falling edge, capture, then run three more cycles
    task automatic bus_op(input logic [1:0] ph, input logic wr, input logic [2:0] idx,
                          input logic [15:0] din, input logic uds_n, input logic lds_n,
                          input logic base_ok);
        @(negedge clk);
        bus_phase = ph; cpu_sel = 1'b1; cpu_rw = !wr;
        cpu_addr  = {(base_ok ? 20'hFF860 : 20'hFF861), idx};
        cpu_din = din; cpu_uds_n = uds_n; cpu_lds_n = lds_n;
        #1;
        c_dout = cpu_dout; c_wr = dsk_wr; c_rd = dsk_rd;
        c_hd = dsk_hd_regs; c_reg = dsk_reg; c_wd = dsk_wdata;
        @(negedge clk);
        cpu_sel = 1'b0; cpu_uds_n = 1'b1; cpu_lds_n = 1'b1; bus_phase = ph + 2'd1;
        #1 c_st1 = dma_start;
        @(negedge clk); bus_phase = ph + 2'd2;
        #1 c_st2 = dma_start;
        @(negedge clk); bus_phase = ph + 2'd3;
    endtask

    // Model update for an accepted write
    task automatic model_write(input logic [2:0] idx, input logic [15:0] d,
                               input logic hi, input logic lo);
        if (lo && idx == 3'd4) m_addr[23:16] = d[7:0];
        if (lo && idx == 3'd5) m_addr[15:8]  = d[7:0];
        if (lo && idx == 3'd6) m_addr[7:0]   = d[7:0];
        if (lo && idx == 3'd2 && m_mode[4]) m_cnt = d[7:0];
        if (idx == 3'd3) m_mode = f_mode(m_mode, d, hi, lo);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: writes during reset are ignored
        bus_op(2'd0, 1'b1, 3'd6, 16'h00AB, 1'b0, 1'b0, 1'b1);
        chk("R1 dsk_wr in reset", c_wr, 0);
        bus_op(2'd0, 1'b1, 3'd3, 16'h0110, 1'b0, 1'b0, 1'b1);
        chk("R1 addr", dma_addr, 0);
        chk("R1 count", dma_count, 0);
        chk("R1 dma_off", dma_off, 1);
        chk("R1 dir", dma_dir_out, 0);
        chk("R1 floppy", dma_floppy, 0);
        chk("R1 start", dma_start, 0);
        @(negedge clk) rst_n = 1'b1;

        bus_op(2'd0, 1'b0, 3'd3, 16'h0, 1'b0, 1'b0, 1'b1);
        chk("R4 mode reset readback", c_dout, 16'h0040);

        // R3: address bytes
        bus_op(2'd0, 1'b1, 3'd4, 16'h77FC, 1'b0, 1'b0, 1'b1);
        bus_op(2'd0, 1'b1, 3'd5, 16'h0012, 1'b1, 1'b0, 1'b1);
        bus_op(2'd0, 1'b1, 3'd6, 16'h0034, 1'b1, 1'b0, 1'b1);
        m_addr = 24'hFC1234;
        chk("R3 address", dma_addr, 24'hFC1234);
        bus_op(2'd0, 1'b0, 3'd5, 16'h0, 1'b1, 1'b1, 1'b1);
        chk("R8 R3 mid readback", c_dout, 16'h0012);
        bus_op(2'd0, 1'b1, 3'd6, 16'h0099, 1'b0, 1'b1, 1'b1);
        chk("R3 upper lane only", dma_addr, 24'hFC1234);

        // R2: wrong slot, wrong base
        bus_op(2'd2, 1'b1, 3'd6, 16'h0055, 1'b0, 1'b0, 1'b1);
        chk("R2 non-zero slot", dma_addr, 24'hFC1234);
        bus_op(2'd0, 1'b1, 3'd4, 16'h0055, 1'b0, 1'b0, 1'b0);
        chk("R2 wrong base", dma_addr, 24'hFC1234);
        bus_op(2'd0, 1'b0, 3'd4, 16'h0, 1'b1, 1'b1, 1'b0);
        chk("R2 wrong base read", c_dout, 0);

        // R4: mode lanes and reserved bits
        bus_op(2'd0, 1'b1, 3'd3, 16'hFFFF, 1'b0, 1'b0, 1'b1);
        bus_op(2'd0, 1'b0, 3'd3, 16'h0, 1'b1, 1'b1, 1'b1);
        chk("R4 mode all ones", c_dout, 16'h01DE);
        chk("R4 outputs", {dma_dir_out, dma_floppy, dma_off}, 3'b111);
        bus_op(2'd0, 1'b1, 3'd3, 16'h0000, 1'b0, 1'b1, 1'b1);
        bus_op(2'd0, 1'b0, 3'd3, 16'h0, 1'b1, 1'b1, 1'b1);
        chk("R4 upper lane only", c_dout, 16'h00DE);

        // R5/R6: sector count
        bus_op(2'd0, 1'b1, 3'd3, 16'h0010, 1'b0, 1'b0, 1'b1);
        bus_op(2'd0, 1'b1, 3'd2, 16'h0000, 1'b1, 1'b0, 1'b1);
        chk("R6 zero count no start", c_st1, 0);
        bus_op(2'd0, 1'b1, 3'd2, 16'h0005, 1'b1, 1'b0, 1'b1);
        chk("R6 start pulse", c_st1, 1);
        chk("R6 start one cycle", c_st2, 0);
        chk("R5 count", dma_count, 5);
        bus_op(2'd0, 1'b0, 3'd2, 16'h0, 1'b1, 1'b1, 1'b1);
        chk("R5 count readback", c_dout, 16'h0005);

        // R7: controller path
        bus_op(2'd0, 1'b1, 3'd3, 16'h008C, 1'b0, 1'b0, 1'b1);
        bus_op(2'd0, 1'b1, 3'd2, 16'h00A5, 1'b1, 1'b0, 1'b1);
        chk("R7 dsk_wr", c_wr, 1);
        chk("R7 dsk fields", {c_wd, c_reg, c_hd}, {8'hA5, 2'd2, 1'b1});
        chk("R7 count unchanged", dma_count, 5);
        chk("R7 no start", c_st1, 0);
        dsk_rdata = 8'h3C;
        bus_op(2'd0, 1'b0, 3'd2, 16'h0, 1'b1, 1'b1, 1'b1);
        chk("R7 read data", c_dout, 16'h003C);
        chk("R7 dsk_rd", c_rd, 1);

        // R8: unmapped indices
        bus_op(2'd0, 1'b0, 3'd7, 16'h0, 1'b1, 1'b1, 1'b1);
        chk("R8 index 7", c_dout, 0);
        bus_op(2'd0, 1'b0, 3'd0, 16'h0, 1'b1, 1'b1, 1'b1);
        chk("R8 index 0", c_dout, 0);

        m_mode = 9'h08C; m_cnt = 8'h05;
        // Random mix checked against the model (R3 R4 R5 R6 R7 R8)
        for (int i = 0; i < 300; i++) begin
            logic [2:0]  idx  = 3'($urandom_range(0, 7));
            logic        wr   = 1'($urandom);
            logic [15:0] d    = 16'($urandom);
            logic        hi   = 1'($urandom);
            logic        lo   = ($urandom_range(0, 3) != 0);
            logic        e_wr, e_st;
            logic [15:0] e_rd;
            if ($urandom_range(0, 3) == 0) d[7:0] = 8'h00;
            dsk_rdata = 8'($urandom);
            e_rd = f_read(idx, dsk_rdata);
            e_wr = wr && lo && idx == 3'd2 && !m_mode[4];
            e_st = wr && lo && idx == 3'd2 && m_mode[4] && d[7:0] != 0;
            bus_op(2'd0, wr, idx, d, !hi, !lo, 1'b1);
            if (wr) model_write(idx, d, hi, lo);
            else chk("R8 random read", c_dout, e_rd);
            chk("R7 random dsk_wr", c_wr, e_wr);
            chk("R6 random start", c_st1, e_st);
            chk("R3 random addr", dma_addr, m_addr);
            chk("R5 random count", dma_count, m_cnt);
            chk("R4 random mode outs", {dma_dir_out, dma_floppy, dma_off, dsk_hd_regs, dsk_reg},
                {m_mode[8], m_mode[7], m_mode[6], m_mode[3], m_mode[2:1]});
        end

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            total++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule